// File: doc/BRIEF.md
# Wireless Key Cache Table

A table of per-peer cipher key records for a wireless MAC. Each record holds five key words, a cipher type word and the peer address words, all reached by software through a 32-bit register port. Internally the table is 64 bits wide. Software writes a record as pairs of 32-bit words, even word first. The even word waits in a staging register, and the whole pair is stored only when the odd word of the pair arrives.

The peer address is kept shifted right by one bit. The low address word holds bits 32:1 of the 48-bit address, and the high address word holds bits 47:33 in its low 15 bits. Bit 15 of the high address word is the record's valid flag. A second, independent port takes the 48-bit address of a received frame and searches every record at once. One clock later it returns whether a valid record matched, the index of the lowest matching record, its five key words and its type word.

Records that carry a companion integrity key, placed 64 slots above their owner, are written by software with the valid flag clear, so they never answer a search. Choosing cipher types and policies is left to software.

Top module: `wkc_table`

## Requirements
- R1: Word w (0..7) of record N sits at byte address 0x800 + 32*N + 4*w, in the order key0, key1, key2, key3, key4, type, addr_lo, addr_hi. An access whose address is below 0x800, at or above 0x800 + 32*DEPTH, or not a multiple of four is ignored: a write changes nothing, including the staging register, and a read returns zero.
- R2: A write to an even word (w = 0, 2, 4, 6) only loads the staging register. Reading the record afterwards still returns the previously stored value of that word.
- R3: A write to an odd word stores the whole pair in the same clock. The odd half takes the written data, and the even half takes the current staging value, even if that value came from a write to a different pair or record. The staging register is zero after reset.
- R4: Bits with no meaning are stored and read as zero. These are bits 31:16 of key1, key3 and addr_hi, and the bits of the type word above TYPE_W (default 4).
- R5: A read issued with host_re returns the stored word on host_rdata one clock later. host_rdata holds that value until the next read.
- R6: One clock after lk_req, lk_hit is 1 when some record has addr_hi bit 15 set and {addr_hi[14:0], addr_lo} equal to lk_addr[47:1]. Bit 0 of lk_addr takes no part in the compare.
- R7: When several records match, lk_index reports the lowest matching index.
- R8: On a hit, lk_key carries key0 in bits 31:0, key1 in 63:32, key2 in 95:64, key3 in 127:96 and key4 in 159:128, and lk_type carries the type word. On a miss, or in a cycle after no request, lk_hit, lk_index, lk_key and lk_type are all zero.
- R9: A record whose addr_hi bit 15 is clear never matches, whatever its address bits hold.
- R10: An active-low synchronous reset clears every record, the staging register and all outputs.
- R11: A search sees the table as it stood before the clock edge that samples the request. A pair stored at that same edge is not seen.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| host_we | input | 1 | Host write strobe |
| host_re | input | 1 | Host read strobe |
| host_addr | input | ADDR_W | Host byte address |
| host_wdata | input | 32 | Host write data |
| host_rdata | output | 32 | Host read data, registered |
| lk_req | input | 1 | Search request |
| lk_addr | input | 48 | Received peer address |
| lk_hit | output | 1 | A valid record matched |
| lk_index | output | IDX_W | Lowest matching record index |
| lk_key | output | 160 | Five key words of the matching record |
| lk_type | output | 32 | Type word of the matching record |

## Verification
The search properties assume the table does not change between the edge that samples a request and the edge that registers the result. Since both happen at the same edge, the checker keeps its own copy of the match and valid vectors taken at that edge. The read-data properties assume the table base is aligned to 32 bytes, so that address bits 4:2 name the word. The stimulus uses only aligned in-range addresses for its random traffic. It places out-of-range and misaligned accesses, and the one write that coincides with a search, in directed steps whose expected results the bench model computes before it applies the write.

// File: rtl/wkc_pkg.sv
// Package: shared types and field rules for the key cache table.
// Assumes records of eight 32-bit words grouped into four 64-bit pairs.
package wkc_pkg;
    localparam int unsigned WORDS = 8;
    localparam int unsigned PAIRS = 4;

    typedef logic [63:0] pair_t;

    // Significant-bit mask of one record word; type_w must be below 32.
    function automatic logic [31:0] word_mask(input logic [2:0] w, input int unsigned type_w);
        logic [31:0] m;
        case (w)
            3'd1, 3'd3, 3'd7: m = 32'h0000_FFFF;
            3'd5:             m = (32'h1 << type_w) - 32'h1;
            default:          m = 32'hFFFF_FFFF;
        endcase
        return m;
    endfunction
endpackage

// File: rtl/wkc_host_if.sv
// Host-side decode and even-word staging.
// Decodes a byte address into record index and word number. It holds even
// words in one staging register and raises a commit strobe with a full
// 64-bit pair when an odd word is written. Assumes BASE is a multiple of 32.
module wkc_host_if #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned BASE   = 32'h800,
    parameter int unsigned TYPE_W = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH),
    localparam int unsigned SPAN  = DEPTH * 32
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [ADDR_W-1:0]     addr,
    input  logic [31:0]           wdata,
    output logic                  dec_ok,
    output logic [IDX_W-1:0]      dec_idx,
    output logic [2:0]            dec_word,
    output logic                  commit,
    output logic [1:0]            commit_pair,
    output wkc_pkg::pair_t        commit_data
);
    logic [31:0] a32;
    logic [31:0] off32;
    logic [31:0] stage_q;

    // Address decode: range, alignment, record index and word number.
    always_comb begin
        a32      = 32'(addr);
        off32    = a32 - BASE;
        dec_ok   = (a32 >= BASE) && (off32 < SPAN) && (off32[1:0] == 2'b00);
        dec_idx  = IDX_W'(off32 >> 5);
        dec_word = off32[4:2];
    end

    // Staging register: captures in-range even-word writes.
    always_ff @(posedge clk) begin
        if (!rst_n)
            stage_q <= '0;
        else if (we && dec_ok && !dec_word[0])
            stage_q <= wdata;
    end

    // Pair assembly: odd write plus staged even word, both masked.
    always_comb begin
        commit      = we && dec_ok && dec_word[0];
        commit_pair = dec_word[2:1];
        commit_data = {wdata & wkc_pkg::word_mask(dec_word, TYPE_W),
                       stage_q & wkc_pkg::word_mask({dec_word[2:1], 1'b0}, TYPE_W)};
    end
endmodule

// File: rtl/wkc_store.sv
// Record storage: DEPTH records of four 64-bit pairs, with a registered
// 32-bit read port. It exposes every record's tag (valid flag and shifted
// address) and key/type bundle to the search logic. Assumes that commit data
// is already masked.
module wkc_store #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  commit,
    input  logic [IDX_W-1:0]      commit_idx,
    input  logic [1:0]            commit_pair,
    input  wkc_pkg::pair_t        commit_data,
    input  logic                  rd_en,
    input  logic                  rd_ok,
    input  logic [IDX_W-1:0]      rd_idx,
    input  logic [2:0]            rd_word,
    output logic [31:0]           rdata_q,
    output logic [47:0]           tag_o [DEPTH],
    output logic [191:0]          rec_o [DEPTH]
);
    wkc_pkg::pair_t mem_q [DEPTH][wkc_pkg::PAIRS];

    // Pair write: reset clears all records, a commit replaces one pair.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < int'(DEPTH); i++)
                for (int p = 0; p < int'(wkc_pkg::PAIRS); p++)
                    mem_q[i][p] <= '0;
        end else if (commit) begin
            mem_q[commit_idx][commit_pair] <= commit_data;
        end
    end

    // Host read: selects one half of one pair, zero when out of range.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rdata_q <= '0;
        else if (rd_en)
            rdata_q <= !rd_ok ? 32'h0 :
                       rd_word[0] ? mem_q[rd_idx][rd_word[2:1]][63:32]
                                  : mem_q[rd_idx][rd_word[2:1]][31:0];
    end

    // Search view: tag and key bundle of each record.
    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_view
        assign tag_o[i] = mem_q[i][3][47:0];
        assign rec_o[i] = {mem_q[i][2], mem_q[i][1], mem_q[i][0]};
        logic unused_hi;
        assign unused_hi = |mem_q[i][3][63:48];
    end
endmodule

// File: rtl/wkc_match.sv
// Associative search over all record tags. It compares address bits 47:1
// with every valid tag, picks the lowest matching index and registers the
// hit, the index and the record's keys and type. Assumes tag bit 47 is the
// valid flag and bits 46:0 hold the shifted address.
module wkc_match #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic [47:0]           tag_i [DEPTH],
    input  logic [191:0]          rec_i [DEPTH],
    input  logic                  req,
    input  logic [47:1]           peer,
    output logic                  hit_q,
    output logic [IDX_W-1:0]      idx_q,
    output logic [159:0]          key_q,
    output logic [31:0]           type_q
);
    logic [DEPTH-1:0] hv;
    logic             any;
    logic [IDX_W-1:0] sel;

    // Per-record compare: valid flag set and address bits equal.
    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_cmp
        assign hv[i] = tag_i[i][47] && (tag_i[i][46:0] == peer);
    end

    // Priority pick: the scan runs downward so the lowest index wins.
    always_comb begin
        any = 1'b0;
        sel = '0;
        for (int i = int'(DEPTH) - 1; i >= 0; i--) begin
            if (hv[i]) begin
                any = 1'b1;
                sel = IDX_W'(i);
            end
        end
    end

    // Result register: full result on a hit, all zero otherwise.
    always_ff @(posedge clk) begin
        if (!rst_n || !(req && any)) begin
            hit_q  <= 1'b0;
            idx_q  <= '0;
            key_q  <= '0;
            type_q <= '0;
        end else begin
            hit_q  <= 1'b1;
            idx_q  <= sel;
            key_q  <= rec_i[sel][159:0];
            type_q <= rec_i[sel][191:160];
        end
    end
endmodule

// File: rtl/wkc_table.sv
// Top: key cache table with a 32-bit host port and a search port.
// Connects host decode/staging, storage and associative search. Assumes
// that software writes each pair even word first.
module wkc_table #(
    parameter int unsigned ADDR_W = 13,
    parameter int unsigned DEPTH  = 128,
    parameter int unsigned BASE   = 32'h800,
    parameter int unsigned TYPE_W = 4,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_we,
    input  logic                  host_re,
    input  logic [ADDR_W-1:0]     host_addr,
    input  logic [31:0]           host_wdata,
    output logic [31:0]           host_rdata,
    input  logic                  lk_req,
    input  logic [47:0]           lk_addr,
    output logic                  lk_hit,
    output logic [IDX_W-1:0]      lk_index,
    output logic [159:0]          lk_key,
    output logic [31:0]           lk_type
);
    logic                 dec_ok;
    logic [IDX_W-1:0]     dec_idx;
    logic [2:0]           dec_word;
    logic                 commit;
    logic [1:0]           commit_pair;
    wkc_pkg::pair_t       commit_data;
    logic [47:0]          tag_w [DEPTH];
    logic [191:0]         rec_w [DEPTH];
    logic                 unused_a0;

    assign unused_a0 = lk_addr[0];

    wkc_host_if #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .BASE(BASE), .TYPE_W(TYPE_W)) u_host (
        .clk(clk), .rst_n(rst_n), .we(host_we), .addr(host_addr), .wdata(host_wdata),
        .dec_ok(dec_ok), .dec_idx(dec_idx), .dec_word(dec_word),
        .commit(commit), .commit_pair(commit_pair), .commit_data(commit_data)
    );

    wkc_store #(.DEPTH(DEPTH)) u_store (
        .clk(clk), .rst_n(rst_n), .commit(commit), .commit_idx(dec_idx),
        .commit_pair(commit_pair), .commit_data(commit_data),
        .rd_en(host_re), .rd_ok(dec_ok), .rd_idx(dec_idx), .rd_word(dec_word),
        .rdata_q(host_rdata), .tag_o(tag_w), .rec_o(rec_w)
    );

    wkc_match #(.DEPTH(DEPTH)) u_match (
        .clk(clk), .rst_n(rst_n), .tag_i(tag_w), .rec_i(rec_w),
        .req(lk_req), .peer(lk_addr[47:1]),
        .hit_q(lk_hit), .idx_q(lk_index), .key_q(lk_key), .type_q(lk_type)
    );
endmodule

// File: rtl/wkc_table_chk.sv
// Checker: search and read-port properties of the key cache table.
// Keeps its own copy of the match and valid vectors at each edge so that a
// registered result can be related to the table it was computed from.
module wkc_table_chk #(
    parameter int unsigned DEPTH = 128,
    localparam int unsigned IDX_W = $clog2(DEPTH)
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  host_re,
    input  logic [2:0]            host_word,
    input  logic [31:16]          rdata_hi,
    input  logic                  lk_req,
    input  logic [47:1]           peer,
    input  logic                  lk_hit,
    input  logic [IDX_W-1:0]      lk_index,
    input  logic [159:0]          lk_key,
    input  logic [31:0]           lk_type,
    input  logic [47:0]           tag [DEPTH]
);
    logic [DEPTH-1:0] vld_now, mv_now, vld_d, mv_d;

    // Live valid and match vectors taken from the stored tags.
    for (genvar i = 0; i < int'(DEPTH); i++) begin : g_vec
        assign vld_now[i] = tag[i][47];
        assign mv_now[i]  = tag[i][47] && (tag[i][46:0] == peer);
    end

    // One-cycle copies that line up with the registered search result.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            vld_d <= '0;
            mv_d  <= '0;
        end else begin
            vld_d <= vld_now;
            mv_d  <= mv_now;
        end
    end

    p_hit_has_match_r6: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> mv_d[lk_index]);
    p_match_gives_hit_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (lk_req && (|mv_now)) |=> lk_hit);
    p_lowest_index_r7: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> ((mv_d & ((DEPTH'(1) << lk_index) - DEPTH'(1))) == '0));
    p_idle_zero_r8: assert property (@(posedge clk) disable iff (!rst_n)
        !lk_req |=> (!lk_hit && lk_key == '0 && lk_type == '0));
    p_invalid_silent_r9: assert property (@(posedge clk) disable iff (!rst_n)
        lk_hit |-> vld_d[lk_index]);
    p_key_hi_zero_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (host_re && (host_word == 3'd1 || host_word == 3'd3 || host_word == 3'd7))
        |=> rdata_hi == 16'h0);
endmodule

bind wkc_table wkc_table_chk #(.DEPTH(DEPTH)) u_chk (
    .clk(clk), .rst_n(rst_n), .host_re(host_re), .host_word(host_addr[4:2]),
    .rdata_hi(host_rdata[31:16]), .lk_req(lk_req), .peer(lk_addr[47:1]),
    .lk_hit(lk_hit), .lk_index(lk_index), .lk_key(lk_key), .lk_type(lk_type),
    .tag(tag_w)
);

// File: tb/tb_wkc_table.sv
module tb_wkc_table;
    localparam int unsigned DEPTH  = 128;
    localparam int unsigned ADDR_W = 13;
    localparam int unsigned TYPE_W = 4;
    localparam int unsigned IDX_W  = $clog2(DEPTH);

    logic               clk = 1'b0;
    logic               rst_n = 1'b0;
    logic               host_we = 1'b0, host_re = 1'b0;
    logic [ADDR_W-1:0]  host_addr = '0;
    logic [31:0]        host_wdata = '0;
    logic [31:0]        host_rdata;
    logic               lk_req = 1'b0;
    logic [47:0]        lk_addr = '0;
    logic               lk_hit;
    logic [IDX_W-1:0]   lk_index;
    logic [159:0]       lk_key;
    logic [31:0]        lk_type;

    int n_chk = 0, n_fail = 0;
    bit done = 0;

    logic [31:0] m [DEPTH][8];
    logic [31:0] m_stage;
    logic [47:0] pool [4];

    always #2 clk = ~clk;

    wkc_table #(.ADDR_W(ADDR_W), .DEPTH(DEPTH), .TYPE_W(TYPE_W)) dut (.*);

    function automatic logic [31:0] fmask(input int w);
        if (w == 1 || w == 3 || w == 7) return 32'h0000_FFFF;
        if (w == 5) return (32'h1 << TYPE_W) - 1;
        return 32'hFFFF_FFFF;
    endfunction

    function automatic bit in_rng(input int unsigned a);
        return a >= 32'h800 && a < 32'h800 + DEPTH * 32 && a[1:0] == 2'b00;
    endfunction

    function automatic int unsigned waddr(input int e, input int w);
        return 32'h800 + 32 * e + 4 * w;
    endfunction

    function automatic void m_reset();
        for (int e = 0; e < DEPTH; e++)
            for (int w = 0; w < 8; w++) m[e][w] = '0;
        m_stage = '0;
    endfunction

    function automatic void m_write(input int unsigned a, input logic [31:0] d);
        int e, w;
        if (!in_rng(a)) return;
        e = int'((a - 32'h800) >> 5);
        w = int'(((a - 32'h800) >> 2) & 7);
        if (w % 2 == 0) m_stage = d;
        else begin
            m[e][w]   = d & fmask(w);
            m[e][w-1] = m_stage & fmask(w - 1);
        end
    endfunction

    function automatic logic [31:0] m_read(input int unsigned a);
        if (!in_rng(a)) return '0;
        return m[(a - 32'h800) >> 5][((a - 32'h800) >> 2) & 7];
    endfunction

    // Expected search result: {hit, index, key, type}
    function automatic logic [1+IDX_W+160+32-1:0] m_look(input logic [47:0] pa);
        for (int e = 0; e < DEPTH; e++)
            if (m[e][7][15] && {m[e][7][14:0], m[e][6]} == pa[47:1])
                return {1'b1, IDX_W'(e), m[e][4], m[e][3], m[e][2], m[e][1], m[e][0], m[e][5]};
        return '0;
    endfunction

    task automatic check(input string tag, input logic [191:0] act, input logic [191:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic wr(input int unsigned a, input logic [31:0] d);
        @(negedge clk);
        host_we = 1'b1; host_addr = ADDR_W'(a); host_wdata = d;
        m_write(a, d);
        @(negedge clk);
        host_we = 1'b0;
    endtask

    task automatic rd_chk(input string tag, input int unsigned a);
        @(negedge clk);
        host_re = 1'b1; host_addr = ADDR_W'(a);
        @(negedge clk);
        host_re = 1'b0;
        check(tag, 192'(host_rdata), 192'(m_read(a)));
    endtask

    task automatic lk_chk(input string tag, input logic [47:0] pa);
        logic [1+IDX_W+160+32-1:0] exp;
        @(negedge clk);
        lk_req = 1'b1; lk_addr = pa;
        exp = m_look(pa);
        @(negedge clk);
        lk_req = 1'b0;
        check({tag, " hit/index"}, 192'({lk_hit, lk_index}), 192'(exp[192+IDX_W:192]));
        check({tag, " key/type"}, {lk_key, lk_type}, exp[191:0]);
    endtask

    task automatic install(input int e, input logic [47:0] pa, input bit v, input logic [31:0] ty);
        for (int w = 0; w < 5; w++) wr(waddr(e, w), $urandom);
        wr(waddr(e, 5), ty);
        wr(waddr(e, 6), pa[32:1]);
        wr(waddr(e, 7), {16'h0, v, pa[47:33]});
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        if (!done) begin
            n_fail++;
            $display("FAIL watchdog: run did not finish, actual hung expected done");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin : main
        logic [47:0] y;
        logic [1+IDX_W+160+32-1:0] exp;
        void'($urandom(32'd2024));
        m_reset();
        repeat (4) @(negedge clk);
        rst_n = 1'b1;

        // R10: cleared after reset
        rd_chk("R10 reset rec0 addr_hi", waddr(0, 7));
        rd_chk("R10 reset rec5 key0", waddr(5, 0));
        lk_chk("R10 reset search miss", 48'h0);

        // R2: even word only staged
        wr(waddr(3, 0), 32'hDEAD_BEEF);
        rd_chk("R2 even staged only", waddr(3, 0));
        // R3/R4: odd commits pair, key1 masked
        wr(waddr(3, 1), 32'h1234_5678);
        rd_chk("R3 pair even half", waddr(3, 0));
        rd_chk("R4 key1 upper zero", waddr(3, 1));
        // R3: orphan odd write uses staging from another record
        wr(waddr(4, 2), 32'hA5A5_0001);
        wr(waddr(9, 7), 32'hFFFF_FFFF);
        rd_chk("R3 orphan odd even half", waddr(9, 6));
        rd_chk("R4 addr_hi upper zero", waddr(9, 7));
        // R4: type masked
        wr(waddr(9, 4), 32'h0);
        wr(waddr(9, 5), 32'hFFFF_FFF7);
        rd_chk("R4 type masked", waddr(9, 5));
        // R1: out of range and misaligned ignored
        wr(32'h7F8, 32'h1111_2222);
        wr(waddr(DEPTH, 0), 32'h3333_4444);
        wr(waddr(2, 0) + 2, 32'h5555_6666);
        wr(waddr(2, 1), 32'h0000_0077);
        rd_chk("R1 ignored writes keep staging", waddr(2, 0));
        rd_chk("R1 out of range read zero", waddr(DEPTH, 1));
        rd_chk("R1 below base read zero", 32'h7FC);
        // R5: read holds
        rd_chk("R5 read rec2 key1", waddr(2, 1));
        repeat (3) @(negedge clk);
        check("R5 rdata held", 192'(host_rdata), 192'(m_read(waddr(2, 1))));

        // R6/R8: search hit, bit 0 ignored
        install(12, 48'h0A1B_2C3D_4E5F, 1'b1, 32'h4);
        lk_chk("R6 R8 hit rec12", 48'h0A1B_2C3D_4E5F);
        lk_chk("R6 bit0 ignored", 48'h0A1B_2C3D_4E5E);
        lk_chk("R6 miss other addr", 48'h0A1B_2C3D_4E5C);
        // R9: invalid record never matches (companion slot)
        install(76, 48'h6000_0000_0002, 1'b0, 32'h0);
        lk_chk("R9 invalid no match", 48'h6000_0000_0002);
        install(80, 48'h6000_0000_0002, 1'b1, 32'h2);
        lk_chk("R9 valid later record hits", 48'h6000_0000_0002);
        // R7: lowest index wins
        install(20, 48'h7777_8888_9990, 1'b1, 32'h1);
        install(10, 48'h7777_8888_9990, 1'b1, 32'h3);
        lk_chk("R7 lowest index", 48'h7777_8888_9990);

        // R11: commit at the same edge as the search is not seen
        y = 48'h4242_0000_1234;
        install(30, 48'h0, 1'b0, 32'h5);
        wr(waddr(30, 6), y[32:1]);
        @(negedge clk);
        host_we = 1'b1; host_addr = ADDR_W'(waddr(30, 7)); host_wdata = {16'h0, 1'b1, y[47:33]};
        lk_req = 1'b1; lk_addr = y;
        exp = m_look(y);
        m_write(waddr(30, 7), host_wdata);
        @(negedge clk);
        host_we = 1'b0; lk_req = 1'b0;
        check("R11 same-edge commit unseen", 192'(lk_hit), 192'(exp[192+IDX_W]));
        lk_chk("R11 seen next search", y);

        // Random traffic (R1 R3 R5 R6 R7 R8)
        for (int i = 0; i < 4; i++) pool[i] = {16'($urandom), 32'($urandom)};
        for (int it = 0; it < 400; it++) begin
            int op, e;
            op = int'($urandom % 6);
            e  = int'($urandom % DEPTH);
            case (op)
                0: install(e, pool[$urandom % 4], 1'($urandom), $urandom);
                1: wr(waddr(e, int'($urandom % 8)), $urandom);
                2: rd_chk("R5 random read", waddr(e, int'($urandom % 8)));
                3: lk_chk("R7 random pool search", pool[$urandom % 4]);
                4: lk_chk("R6 random addr search", {16'($urandom), 32'($urandom)});
                default: rd_chk("R3 random read pair", waddr(e, int'($urandom % 8)));
            endcase
        end

        // R10: reset mid-run
        @(negedge clk);
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        m_reset();
        rd_chk("R10 mid-run reset rec12 key0", waddr(12, 0));
        lk_chk("R10 mid-run reset miss", 48'h0A1B_2C3D_4E5F);
        wr(waddr(40, 1), 32'h0000_00AB);
        rd_chk("R10 staging cleared", waddr(40, 0));

        done = 1;
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule